// File: doc/BRIEF.md
# Memory-Mapped Multi-Port Register File

This block holds the 32 general-purpose byte registers of a small processor core. In a single cycle it hands operands to the datapath and takes back one result. The datapath can read two byte operands, or one 16-bit operand taken from an even/odd register pair. It can write back either a single byte or a 16-bit result that lands in a pair. Reads are combinational. Writes take effect on the rising clock edge.

The same registers also occupy data-space addresses 0 to 31. Loads and stores issued to that range act on the register file and not on external memory. The block raises a hit flag so that the surrounding logic can steer the access away from memory. The three highest register pairs serve as 16-bit pointers. Their current values are driven out continuously. A pointer value may itself fall in the low 32 addresses and so point back into the file.

Top module: `gpr_file_top`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears all 32 registers to 0x00.
- R2: With `wr_mode` = 2'b01 the register selected by `wr_idx` takes `wr_data[7:0]` at the clock edge, and no other register changes.
- R3: With `wr_mode` = 2'b10 the register at index {`wr_idx[4:1]`,0} takes `wr_data[7:0]` and the register at {`wr_idx[4:1]`,1} takes `wr_data[15:8]`, so `wr_idx[0]` is ignored. `wr_mode` values 2'b00 and 2'b11 write nothing.
- R4: The byte read ports `rda_data` and `rdb_data` show the registers chosen by `rda_idx` and `rdb_idx` combinationally and independently of each other. Both ports may select the same register.
- R5: `rdw_data` equals {reg[{`rdw_idx[4:1]`,1}], reg[{`rdw_idx[4:1]`,0}]}, so `rdw_idx[0]` is ignored.
- R6: A read of a register that is being written in the same cycle returns the value it held before that clock edge.
- R7: A data-space address below 32 sets `ds_hit`, reads that register on `ds_rdata`, and writes it when `ds_we` is 1. An address of 32 or above clears `ds_hit`, drives `ds_rdata` to 0x00, and writes nothing, whatever its low five bits are.
- R8: When a datapath write and a data-space write hit the same register in one cycle, the datapath value is stored. When they hit different registers, both are stored.
- R9: `ptr_x` = {reg27, reg26}, `ptr_y` = {reg29, reg28} and `ptr_z` = {reg31, reg30}, each with the low byte taken from the even register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rda_idx | input | 5 | Index of byte read port A |
| rda_data | output | 8 | Byte read port A data |
| rdb_idx | input | 5 | Index of byte read port B |
| rdb_data | output | 8 | Byte read port B data |
| rdw_idx | input | 5 | Pair index of the 16-bit read port (bit 0 ignored) |
| rdw_data | output | 16 | 16-bit pair read data |
| wr_mode | input | 2 | Datapath write: 00 none, 01 byte, 10 pair, 11 none |
| wr_idx | input | 5 | Datapath write index |
| wr_data | input | 16 | Datapath write data |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data (0 when no hit) |
| ds_hit | output | 1 | Address lies in the register window |
| ptr_x | output | 16 | Pointer pair from registers 26/27 |
| ptr_y | output | 16 | Pointer pair from registers 28/29 |
| ptr_z | output | 16 | Pointer pair from registers 30/31 |

## Verification
A datapath write-back and a data-space store can fall in the same cycle. The bench provokes this by driving both in one vector. The cases are the same register for a byte write, one half of a pair write, and two different registers. It judges the result by reading every affected register back after the edge and comparing it with a model in which the datapath value wins. The same vectors are probed before the edge, which shows that the read ports still return the old contents.

// File: rtl/gpr_pkg.sv
// Shared constants and types of the general-purpose register file.
// Assumes: register count is even, so pairs and pointers align.
package gpr_pkg;
    localparam int NREG_DEF = 32;   // number of byte registers
    localparam int DW_DEF   = 8;    // register width
    localparam int AW_DEF   = 16;   // data-space address width
    localparam int NPTR     = 3;    // pointer pairs at the top of the file

    typedef enum logic [1:0] {
        WR_NONE = 2'b00,
        WR_BYTE = 2'b01,
        WR_PAIR = 2'b10,
        WR_RSVD = 2'b11
    } wr_mode_e;
endpackage

// File: rtl/gpr_write_ctrl.sv
// Per-register write decode. For every register it merges the datapath
// write (byte or pair) with the data-space store and gives the datapath
// priority. Purely combinational.
// Assumes: ds_hit already qualifies the data-space address range.
module gpr_write_ctrl
    import gpr_pkg::*;
#(
    parameter int NREG = NREG_DEF,
    parameter int DW   = DW_DEF,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [1:0]              wr_mode,
    input  logic [IDXW-1:0]         wr_idx,
    input  logic [2*DW-1:0]         wr_data,
    input  logic                    ds_we,
    input  logic                    ds_hit,
    input  logic [IDXW-1:0]         ds_idx,
    input  logic [DW-1:0]           ds_wdata,
    output logic [NREG-1:0]         reg_we,
    output logic [NREG-1:0][DW-1:0] reg_wd
);
    wr_mode_e mode;
    assign mode = wr_mode_e'(wr_mode);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic dp_sel;
        logic ds_sel;
        logic [DW-1:0] dp_byte;

        // Decide whether the datapath targets register i and with which byte.
        always_comb begin
            dp_sel = ((mode == WR_BYTE) && (wr_idx == IDXW'(i))) ||
                     ((mode == WR_PAIR) && (wr_idx[IDXW-1:1] == (IDXW-1)'(i / 2)));
            if (mode == WR_PAIR && (i % 2) == 1)
                dp_byte = wr_data[2*DW-1:DW];
            else
                dp_byte = wr_data[DW-1:0];
        end

        assign ds_sel = ds_we && ds_hit && (ds_idx == IDXW'(i));

        // Merge both sources; the datapath wins on a collision.
        always_comb begin
            reg_we[i] = dp_sel || ds_sel;
            reg_wd[i] = dp_sel ? dp_byte : ds_wdata;
        end
    end
endmodule

// File: rtl/gpr_storage.sv
// Storage flops of the register file. One write enable and one data byte
// per register; synchronous active-low reset clears everything.
// Assumes: the write decode resolves collisions before this stage.
module gpr_storage
    import gpr_pkg::*;
#(
    parameter int NREG = NREG_DEF,
    parameter int DW   = DW_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0]         reg_we,
    input  logic [NREG-1:0][DW-1:0] reg_wd,
    output logic [NREG-1:0][DW-1:0] regs_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_cell
        // Hold register i, clear on reset, load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (reg_we[i])
                regs_q[i] <= reg_wd[i];
        end
    end
endmodule

// File: rtl/gpr_read_mux.sv
// Combinational read side: two byte ports, one pair port, the data-space
// read and the three pointer pairs at the top of the file.
// Assumes: ds_hit qualifies ds_idx; NREG >= 2*NPTR and NREG is even.
module gpr_read_mux
    import gpr_pkg::*;
#(
    parameter int NREG = NREG_DEF,
    parameter int DW   = DW_DEF,
    localparam int IDXW    = $clog2(NREG),
    localparam int PTRBASE = NREG - 2 * NPTR
) (
    input  logic [NREG-1:0][DW-1:0]   regs_q,
    input  logic [IDXW-1:0]           rda_idx,
    input  logic [IDXW-1:0]           rdb_idx,
    input  logic [IDXW-1:0]           rdw_idx,
    input  logic                      ds_hit,
    input  logic [IDXW-1:0]           ds_idx,
    output logic [DW-1:0]             rda_data,
    output logic [DW-1:0]             rdb_data,
    output logic [2*DW-1:0]           rdw_data,
    output logic [DW-1:0]             ds_rdata,
    output logic [NPTR-1:0][2*DW-1:0] ptr_q
);
    logic [IDXW-1:0] rdw_lo;
    logic [IDXW-1:0] rdw_hi;

    assign rdw_lo = {rdw_idx[IDXW-1:1], 1'b0};
    assign rdw_hi = {rdw_idx[IDXW-1:1], 1'b1};

    // Select byte, pair and data-space read values.
    always_comb begin
        rda_data = regs_q[rda_idx];
        rdb_data = regs_q[rdb_idx];
        rdw_data = {regs_q[rdw_hi], regs_q[rdw_lo]};
        ds_rdata = ds_hit ? regs_q[ds_idx] : '0;
    end

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        assign ptr_q[p] = {regs_q[PTRBASE + 2*p + 1], regs_q[PTRBASE + 2*p]};
    end
endmodule

// File: rtl/gpr_file_top.sv
// Top of the general-purpose register file: datapath ports, data-space
// window at the lowest addresses, and pointer outputs.
// Assumes: the caller routes accesses with ds_hit low to external memory.
module gpr_file_top
    import gpr_pkg::*;
#(
    parameter int NREG = NREG_DEF,
    parameter int DW   = DW_DEF,
    parameter int AW   = AW_DEF,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rda_idx,
    output logic [DW-1:0]   rda_data,
    input  logic [IDXW-1:0] rdb_idx,
    output logic [DW-1:0]   rdb_data,
    input  logic [IDXW-1:0] rdw_idx,
    output logic [2*DW-1:0] rdw_data,
    input  logic [1:0]      wr_mode,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [2*DW-1:0] wr_data,
    input  logic [AW-1:0]   ds_addr,
    input  logic            ds_we,
    input  logic [DW-1:0]   ds_wdata,
    output logic [DW-1:0]   ds_rdata,
    output logic            ds_hit,
    output logic [2*DW-1:0] ptr_x,
    output logic [2*DW-1:0] ptr_y,
    output logic [2*DW-1:0] ptr_z
);
    localparam logic [AW-1:0] DS_LIMIT = AW'(NREG);

    logic [NREG-1:0]           reg_we;
    logic [NREG-1:0][DW-1:0]   reg_wd;
    logic [NREG-1:0][DW-1:0]   regs_q;
    logic [NPTR-1:0][2*DW-1:0] ptr_q;
    logic [IDXW-1:0]           ds_idx;

    // Decode the register window of the data space.
    always_comb begin
        ds_hit = (ds_addr < DS_LIMIT);
        ds_idx = ds_addr[IDXW-1:0];
    end

    gpr_write_ctrl #(.NREG(NREG), .DW(DW)) u_wctl (
        .wr_mode (wr_mode),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ds_we   (ds_we),
        .ds_hit  (ds_hit),
        .ds_idx  (ds_idx),
        .ds_wdata(ds_wdata),
        .reg_we  (reg_we),
        .reg_wd  (reg_wd)
    );

    gpr_storage #(.NREG(NREG), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .reg_we(reg_we),
        .reg_wd(reg_wd),
        .regs_q(regs_q)
    );

    gpr_read_mux #(.NREG(NREG), .DW(DW)) u_rmux (
        .regs_q  (regs_q),
        .rda_idx (rda_idx),
        .rdb_idx (rdb_idx),
        .rdw_idx (rdw_idx),
        .ds_hit  (ds_hit),
        .ds_idx  (ds_idx),
        .rda_data(rda_data),
        .rdb_data(rdb_data),
        .rdw_data(rdw_data),
        .ds_rdata(ds_rdata),
        .ptr_q   (ptr_q)
    );

    assign ptr_x = ptr_q[0];
    assign ptr_y = ptr_q[1];
    assign ptr_z = ptr_q[2];

    // Stored state versus the requests of the previous cycle.
    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode == WR_BYTE) |=> (regs_q[$past(wr_idx)] == $past(wr_data[DW-1:0]))); // R2

    AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode == WR_PAIR) |=>
            (regs_q[{$past(wr_idx[IDXW-1:1]), 1'b0}] == $past(wr_data[DW-1:0])) &&
            (regs_q[{$past(wr_idx[IDXW-1:1]), 1'b1}] == $past(wr_data[2*DW-1:DW]))); // R3

    AST_DS_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_hit && wr_mode != WR_BYTE && wr_mode != WR_PAIR) |=> $stable(regs_q)); // R7

    AST_DP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && ds_hit && wr_mode == WR_BYTE && wr_idx == ds_idx) |=>
            (regs_q[$past(ds_idx)] == $past(wr_data[DW-1:0]))); // R8
endmodule

// File: tb/gpr_file_top_tb_top.sv
module gpr_file_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rda_idx = '0, rdb_idx = '0, rdw_idx = '0, wr_idx = '0;
    logic [1:0]  wr_mode = '0;
    logic [15:0] wr_data = '0, ds_addr = '0;
    logic        ds_we = 1'b0;
    logic [7:0]  ds_wdata = '0;
    logic [7:0]  rda_data, rdb_data, ds_rdata;
    logic [15:0] rdw_data, ptr_x, ptr_y, ptr_z;
    logic        ds_hit;

    always #2.5 clk = ~clk;   // 200 MHz

    gpr_file_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .rda_idx(rda_idx), .rda_data(rda_data),
        .rdb_idx(rdb_idx), .rdb_data(rdb_data),
        .rdw_idx(rdw_idx), .rdw_data(rdw_data),
        .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .ds_hit(ds_hit),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  idx;
        logic [15:0] data;
        logic        dswe;
        logic [15:0] dsa;
        logic [7:0]  dsd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 5'd3,  16'h00A5, 1'b0, 16'd0,   8'h00},  // byte write
        '{2'b10, 5'd26, 16'h1234, 1'b0, 16'd0,   8'h00},  // pair into X
        '{2'b10, 5'd29, 16'hBEEF, 1'b0, 16'd0,   8'h00},  // odd pair index
        '{2'b00, 5'd5,  16'h0000, 1'b1, 16'd5,   8'h77},  // data-space store
        '{2'b00, 5'd8,  16'h0000, 1'b1, 16'd40,  8'h99},  // store outside window
        '{2'b01, 5'd7,  16'h0011, 1'b1, 16'd7,   8'h22},  // collision, same reg
        '{2'b01, 5'd8,  16'h0033, 1'b1, 16'd9,   8'h44},  // two different regs
        '{2'b10, 5'd30, 16'hCAFE, 1'b1, 16'd31,  8'h55},  // collision on pair half
        '{2'b11, 5'd3,  16'hFFFF, 1'b0, 16'd0,   8'h00},  // reserved mode
        '{2'b00, 5'd3,  16'h0000, 1'b1, 16'd259, 8'h00},  // aliasing miss
        '{2'b10, 5'd0,  16'h0102, 1'b1, 16'd2,   8'h66}   // pair plus other reg
    };

    logic [7:0] m [32];
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one vector, probe old values before the edge, then check after.
    task automatic step(input vec_t v);
        logic [7:0] nm [32];
        @(negedge clk);
        wr_mode = v.mode; wr_idx = v.idx; wr_data = v.data;
        ds_we = v.dswe; ds_addr = v.dsa; ds_wdata = v.dsd;
        rda_idx = v.idx; rdb_idx = v.idx | 5'd1;
        #1;
        chk("R6 old value before edge", {8'h0, rda_data}, {8'h0, m[v.idx]});
        chk("R7 hit flag", {15'h0, ds_hit}, {15'h0, v.dsa < 16'd32});
        nm = m;
        if (v.dswe && v.dsa < 16'd32) nm[v.dsa[4:0]] = v.dsd;
        if (v.mode == 2'b01) nm[v.idx] = v.data[7:0];
        if (v.mode == 2'b10) begin
            nm[v.idx & 5'h1E] = v.data[7:0];
            nm[v.idx | 5'h01] = v.data[15:8];
        end
        @(negedge clk);
        m = nm;
        wr_mode = 2'b00; ds_we = 1'b0;
        rdw_idx = v.idx;
        #1;
        chk("R2/R3 target byte", {8'h0, rda_data}, {8'h0, m[v.idx]});
        chk("R3 odd partner", {8'h0, rdb_data}, {8'h0, m[v.idx | 5'd1]});
        chk("R5 pair read", rdw_data, {m[v.idx | 5'd1], m[v.idx & 5'h1E]});
        chk("R7/R8 data-space read", {8'h0, ds_rdata},
            {8'h0, (v.dsa < 16'd32) ? m[v.dsa[4:0]] : 8'h00});
        chk("R9 ptr_x", ptr_x, {m[27], m[26]});
        chk("R9 ptr_y", ptr_y, {m[29], m[28]});
        chk("R9 ptr_z", ptr_z, {m[31], m[30]});
    endtask

    // Compare every register through both byte ports.
    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            rda_idx = 5'(i); rdb_idx = 5'(31 - i);
            #1;
            chk(req, {8'h0, rda_data}, {8'h0, m[i]});
            chk(req, {8'h0, rdb_data}, {8'h0, m[31 - i]});
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        sweep("R1 reset clears");                       // R1
        chk("R9 ptr after reset", ptr_z, 16'h0000);

        for (int k = 0; k < NV; k++) step(VECS[k]);

        sweep("R4 full readback");                      // R4, R8 final state
        // R7: both byte ports on one register plus data-space read of it.
        @(negedge clk);
        rda_idx = 5'd7; rdb_idx = 5'd7; ds_addr = 16'd7;
        #1;
        chk("R4 same register on A", {8'h0, rda_data}, 16'h0011);
        chk("R4 same register on B", {8'h0, rdb_data}, 16'h0011);
        chk("R8 collision kept datapath", {8'h0, ds_rdata}, 16'h0011);
        ds_addr = 16'd1027;   // low bits 3, outside window
        #1;
        chk("R7 miss reads zero", {8'h0, ds_rdata}, 16'h0000);

        // R1: reset during a pending write clears everything.
        @(negedge clk);
        rst_n = 1'b0; wr_mode = 2'b01; wr_idx = 5'd4; wr_data = 16'h00EE;
        @(negedge clk);
        rst_n = 1'b1; wr_mode = 2'b00;
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        #1;
        sweep("R1 reset over write");
        chk("R1 ptr_x cleared", ptr_x, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule